// File: doc/BRIEF.md
# Dead-Time Gate Command Controller

This block sits between a one-bit PWM modulator and the level shifters of a class D output stage. Each output leg has one high-side and one low-side switch. For every leg the block produces an on/off command for both switches, and it never lets the two be on at once: whenever the wanted state of a leg changes, both switches go off for a programmable number of clock cycles before the new one turns on.

The stage runs in one of two arrangements. The mode pin selects the arrangement and is captured while reset is held, so it stays fixed until the next reset. In bridged mode, legs are paired: the even input of each pair drives both legs of the pair in opposite phase, and the odd input is unused. In single-ended mode, every input drives its own leg.

A mute request takes effect at the next transition of an active input, so no leg is cut in the middle of a switching event. Thermal, overcurrent and data-loss indications are synchronised and latched, and each one is reported on its own status bit. Any latched fault holds every switch off until the next reset. Reset also holds every switch off.

Top module: `dts_gate_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every bit of `hs_on_o`, `ls_on_o` and `flt_stat_o` is 0.
- R2: The mode is the value of `mode_bridge_i` on the last clock edge at which `rst` is high (1 = bridged, 0 = single-ended). Later changes of the pin have no effect until the next reset.
- R3: In bridged mode, for each leg pair 2k/2k+1, a 1 on `pwm_i[2k]` requests the high side of leg 2k and the low side of leg 2k+1. A 0 requests the low side of leg 2k and the high side of leg 2k+1. Bit i of every leg vector belongs to leg i.
- R4: In single-ended mode, a 1 on `pwm_i[i]` requests the high side of leg i and a 0 requests its low side.
- R5: In bridged mode, the odd `pwm_i` bits change no output and do not count as input transitions.
- R6: `hs_on_o[i]` and `ls_on_o[i]` are never 1 in the same cycle.
- R7: When the request of a leg changes, both of its switches are off for exactly `DT_CYC` cycles, and then the requested switch turns on. A further change inside that interval restarts it.
- R8: A change of `pwm_i` sampled at clock edge 1 switches the affected legs off at edge 2, and the new switch turns on at edge `DT_CYC`+2.
- R9: If `mute_i` is high at the edge where a transition of an active input is detected (edge 2), every switch is off from edge 3. The outputs stay off until a transition is detected while `mute_i` is low. Raising `mute_i` without an input transition changes nothing.
- R10: A fault input (`flt_i` bits: 0 thermal, 1 overcurrent, 2 data loss) high at edge 1 sets its status bit at edge `SYNC_STAGES`+1. It forces every switch off from the edge after that, and stays set until reset, even if the input was a one-cycle pulse.
- R11: Each fault condition sets only its own bit of `flt_stat_o`, and the bits accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset / power-down |
| mode_bridge_i | input | 1 | Mode select captured during reset: 1 bridged, 0 single-ended |
| pwm_i | input | NLEGS | One-bit PWM inputs, bit i for leg i |
| mute_i | input | 1 | Mute request |
| flt_i | input | NFLT | Raw fault indications: bit 0 thermal, 1 overcurrent, 2 data loss |
| hs_on_o | output | NLEGS | High-side switch on commands |
| ls_on_o | output | NLEGS | Low-side switch on commands |
| flt_stat_o | output | NFLT | Latched fault status, one bit per condition |

## Verification
The timing of each result is fixed by the registers in its path. Leg outputs go off two edges after a PWM change is sampled and the new switch turns on `DT_CYC`+2 edges after it. A mute applies on the third edge after the triggering transition. A fault shows on status at `SYNC_STAGES`+1 edges and forces the switches off one edge later. The bench drives every stimulus on a falling edge and samples exactly k falling edges later, with k derived from these counts, so it probes both the last cycle before each change and the first cycle after it. A behavioural model advanced on every rising edge is also compared with all outputs on every falling edge.

// File: rtl/dts_pkg.sv
`timescale 1ns/1ps
package dts_pkg;

  // Requested state of one leg
  typedef enum logic [1:0] {
    SW_OFF  = 2'd0,
    SW_HIGH = 2'd1,
    SW_LOW  = 2'd2
  } sw_cmd_e;

endpackage

// File: rtl/dts_fault_latch.sv
`timescale 1ns/1ps
// Synchroniser chain plus sticky latch for each fault indication (R10, R11)
module dts_fault_latch #(
  parameter int NFLT        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] flt_i,
  output logic [NFLT-1:0] flt_lat_o
);

  logic [SYNC_STAGES-1:0][NFLT-1:0] sync_q;
  logic [NFLT-1:0]                  lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= flt_i;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  // One latch per condition; only reset clears it
  for (genvar f = 0; f < NFLT; f++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        lat_q[f] <= 1'b0;
      end else if (sync_q[SYNC_STAGES-1][f]) begin
        lat_q[f] <= 1'b1;
      end
    end
  end

  assign flt_lat_o = lat_q;

endmodule

// File: rtl/dts_input_map.sv
`timescale 1ns/1ps
// Mode capture, input registering, mode-dependent mapping and mute gating
module dts_input_map
  import dts_pkg::*;
#(
  parameter int NLEGS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_i,
  input  logic [NLEGS-1:0]          pwm_i,
  input  logic                      mute_i,
  input  logic                      flt_any_i,
  output sw_cmd_e [NLEGS-1:0]       req_o,
  output logic                      mode_br_o
);

  function automatic logic [NLEGS-1:0] even_mask_f();
    logic [NLEGS-1:0] m;
    for (int i = 0; i < NLEGS; i++) begin
      m[i] = ((i % 2) == 0);
    end
    return m;
  endfunction

  localparam logic [NLEGS-1:0] BR_MASK = even_mask_f();

  logic             mode_q;
  logic [NLEGS-1:0] pwm_q;
  logic [NLEGS-1:0] pwm_p;
  logic             muted_q;
  logic [NLEGS-1:0] cmd_br;
  logic [NLEGS-1:0] cmd;
  logic [NLEGS-1:0] act_mask;
  logic             in_edge;
  logic             enable;

  // Mode follows the pin only while reset is held (R2)
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q   <= '0;
      pwm_p   <= '0;
      muted_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      pwm_p <= pwm_q;
      // Mute state only moves on an input transition (R9)
      if (in_edge) begin
        muted_q <= mute_i;
      end
    end
  end

  // Bridged: even input drives the pair in opposite phase (R3)
  for (genvar g = 0; g < NLEGS; g++) begin : g_map
    if ((g % 2) == 0) begin : g_even
      assign cmd_br[g] = pwm_q[g];
    end else begin : g_odd
      assign cmd_br[g] = ~pwm_q[g-1];
    end
    assign req_o[g] = !enable ? SW_OFF : (cmd[g] ? SW_HIGH : SW_LOW);
  end

  always_comb begin
    cmd      = mode_q ? cmd_br : pwm_q;
    act_mask = mode_q ? BR_MASK : '1;
    in_edge  = |((pwm_q ^ pwm_p) & act_mask);
    enable   = !muted_q && !flt_any_i;
  end

  assign mode_br_o = mode_q;

endmodule

// File: rtl/dts_leg.sv
`timescale 1ns/1ps
// One output leg: nonoverlap interval with restart on every request change
module dts_leg
  import dts_pkg::*;
#(
  parameter int DT_CYC = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  sw_cmd_e req_i,
  output logic    hs_o,
  output logic    ls_o
);

  localparam int CW = (DT_CYC < 2) ? 1 : $clog2(DT_CYC + 1);

  sw_cmd_e         tgt_q;
  sw_cmd_e         tgt_n;
  sw_cmd_e         drv_n;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_n;
  logic            hs_q;
  logic            ls_q;

  always_comb begin
    tgt_n = tgt_q;
    cnt_n = cnt_q;
    drv_n = hs_q ? SW_HIGH : (ls_q ? SW_LOW : SW_OFF);
    if (req_i != tgt_q) begin
      tgt_n = req_i;
      cnt_n = CW'(DT_CYC);
      drv_n = SW_OFF;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      drv_n = (cnt_q == CW'(1)) ? tgt_q : SW_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= SW_OFF;
      cnt_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      tgt_q <= tgt_n;
      cnt_q <= cnt_n;
      hs_q  <= (drv_n == SW_HIGH);
      ls_q  <= (drv_n == SW_LOW);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

endmodule

// File: rtl/dts_gate_ctrl.sv
`timescale 1ns/1ps
// Top: mode-configurable dead-time gate command controller
module dts_gate_ctrl #(
  parameter int NLEGS       = 4,
  parameter int NFLT        = 3,
  parameter int DT_CYC      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_bridge_i,
  input  logic [NLEGS-1:0] pwm_i,
  input  logic             mute_i,
  input  logic [NFLT-1:0]  flt_i,
  output logic [NLEGS-1:0] hs_on_o,
  output logic [NLEGS-1:0] ls_on_o,
  output logic [NFLT-1:0]  flt_stat_o
);

  dts_pkg::sw_cmd_e [NLEGS-1:0] req;
  logic [NFLT-1:0]              flt_lat;
  logic                         mode_br;

  dts_fault_latch #(
    .NFLT        (NFLT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_flt (
    .clk       (clk),
    .rst       (rst),
    .flt_i     (flt_i),
    .flt_lat_o (flt_lat)
  );

  dts_input_map #(
    .NLEGS (NLEGS)
  ) u_map (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_bridge_i),
    .pwm_i     (pwm_i),
    .mute_i    (mute_i),
    .flt_any_i (|flt_lat),
    .req_o     (req),
    .mode_br_o (mode_br)
  );

  for (genvar g = 0; g < NLEGS; g++) begin : g_leg
    dts_leg #(
      .DT_CYC (DT_CYC)
    ) u_leg (
      .clk   (clk),
      .rst   (rst),
      .req_i (req[g]),
      .hs_o  (hs_on_o[g]),
      .ls_o  (ls_on_o[g])
    );
  end

  assign flt_stat_o = flt_lat;

endmodule

// File: rtl/dts_gate_ctrl_chk.sv
`timescale 1ns/1ps
module dts_gate_ctrl_chk #(
  parameter int NLEGS  = 4,
  parameter int NFLT   = 3,
  parameter int DT_CYC = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NLEGS-1:0] hs_on,
  input logic [NLEGS-1:0] ls_on,
  input logic [NFLT-1:0]  flt_stat,
  input logic             mode_br
);

  localparam int OW = $clog2(DT_CYC + 2) + 1;

  // R6
  shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_on & ls_on) == '0);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_br));

  // R10
  flt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_stat != '0) |=> ((flt_stat & $past(flt_stat)) == $past(flt_stat)));

  // R10
  flt_force_off_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_stat != '0) |=> (hs_on == '0 && ls_on == '0));

  for (genvar g = 0; g < NLEGS; g++) begin : g_leg
    logic [OW-1:0] off_cnt;

    always_ff @(posedge clk) begin
      if (rst || hs_on[g] || ls_on[g]) begin
        off_cnt <= '0;
      end else if (off_cnt <= OW'(DT_CYC)) begin
        off_cnt <= off_cnt + 1'b1;
      end
    end

    // R7
    dead_time_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(hs_on[g]) || $rose(ls_on[g])) |-> (off_cnt >= OW'(DT_CYC)));
  end

  for (genvar p = 0; p + 1 < NLEGS; p += 2) begin : g_pair
    // R3
    bridge_phase_chk: assert property (@(posedge clk) disable iff (rst)
      mode_br |-> (!(hs_on[p] && hs_on[p+1]) && !(ls_on[p] && ls_on[p+1])));
  end

endmodule

bind dts_gate_ctrl dts_gate_ctrl_chk #(
  .NLEGS  (NLEGS),
  .NFLT   (NFLT),
  .DT_CYC (DT_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hs_on    (hs_on_o),
  .ls_on    (ls_on_o),
  .flt_stat (flt_stat_o),
  .mode_br  (mode_br)
);

// File: tb/dts_gate_ctrl_tb.sv
`timescale 1ns/1ps
module dts_gate_ctrl_tb;

  localparam int DT = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_pin;
  logic [3:0] pwm;
  logic       mute;
  logic [2:0] flt;
  logic [3:0] hs_on;
  logic [3:0] ls_on;
  logic [2:0] stat;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    chk_en = 1'b0;
  bit    done   = 1'b0;
  string cur    = "R1";

  always #2 clk = ~clk;

  dts_gate_ctrl u_dut (
    .clk           (clk),
    .rst           (rst),
    .mode_bridge_i (mode_pin),
    .pwm_i         (pwm),
    .mute_i        (mute),
    .flt_i         (flt),
    .hs_on_o       (hs_on),
    .ls_on_o       (ls_on),
    .flt_stat_o    (stat)
  );

  // ---------------- behavioural reference ----------------
  int         m_tgt [4];   // 0 off, 1 high, 2 low
  int         m_out [4];
  int         m_cnt [4];
  bit         m_mode;
  logic [3:0] m_pq, m_pp;
  bit         m_muted;
  logic [2:0] m_s1, m_s2, m_lat;
  logic [3:0] m_want;
  logic [3:0] m_msk;
  bit         m_edge, m_en;
  int         m_rq;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = mode_pin;
      m_pq = '0; m_pp = '0; m_muted = 0;
      m_s1 = '0; m_s2 = '0; m_lat = '0;
      for (int l = 0; l < 4; l++) begin
        m_tgt[l] = 0; m_out[l] = 0; m_cnt[l] = 0;
      end
    end else begin
      if (m_mode) m_want = {~m_pq[2], m_pq[2], ~m_pq[0], m_pq[0]};
      else        m_want = m_pq;
      m_msk  = m_mode ? 4'b0101 : 4'b1111;
      m_edge = (((m_pq ^ m_pp) & m_msk) != 0);
      m_en   = !m_muted && (m_lat == 0);
      for (int l = 0; l < 4; l++) begin
        m_rq = !m_en ? 0 : (m_want[l] ? 1 : 2);
        if (m_rq != m_tgt[l]) begin
          m_tgt[l] = m_rq; m_out[l] = 0; m_cnt[l] = DT;
        end else if (m_cnt[l] > 0) begin
          m_cnt[l]--;
          m_out[l] = (m_cnt[l] == 0) ? m_tgt[l] : 0;
        end
      end
      if (m_edge) m_muted = mute;
      m_lat = m_lat | m_s2;
      m_s2  = m_s1;
      m_s1  = flt;
      m_pp  = m_pq;
      m_pq  = pwm;
    end
  end

  function automatic logic [7:0] model_vec();
    logic [3:0] h, s;
    for (int l = 0; l < 4; l++) begin
      h[l] = (m_out[l] == 1);
      s[l] = (m_out[l] == 2);
    end
    return {h, s};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk({hs_on, ls_on} == model_vec(), cur, {hs_on, ls_on}, model_vec());
      chk(stat == m_lat, cur, {5'd0, stat}, {5'd0, m_lat});
      chk((hs_on & ls_on) == 0, "R6", {hs_on, ls_on}, {hs_on, 4'h0});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [3:0] h, input logic [3:0] s, input string tag);
    chk({hs_on, ls_on} == {h, s}, tag, {hs_on, ls_on}, {h, s});
  endtask

  task automatic finish_tb();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_tb();
  end

  task automatic fault_pulse(input logic [2:0] v, input logic [2:0] stat_exp);
    flt = v; wait_n(1);
    flt = '0; wait_n(1);                                   // k=2
    chk(stat == (stat_exp & ~v) | (stat & v & 3'b000) ? 1'b1 : (stat == (stat_exp & ~v)),
        "R10", {5'd0, stat}, {5'd0, stat_exp & ~v});
    wait_n(1);                                             // k=3
    chk(stat == stat_exp, "R11", {5'd0, stat}, {5'd0, stat_exp});
    wait_n(1);                                             // k=4
    expect_out(4'h0, 4'h0, "R10");
  endtask

  initial begin
    rst = 1'b1; mode_pin = 1'b1; pwm = '0; mute = 1'b0; flt = '0;
    wait_n(4);
    chk_en = 1'b1;
    expect_out(4'h0, 4'h0, "R1");
    rst = 1'b0;
    wait_n(1);
    expect_out(4'h0, 4'h0, "R1");
    chk(stat == 0, "R1", {5'd0, stat}, 8'h0);

    // bridged mapping
    cur = "R3";
    wait_n(DT + 3);
    expect_out(4'b1010, 4'b0101, "R3");
    pwm = 4'b0101;
    wait_n(DT + 3);
    expect_out(4'b0101, 4'b1010, "R3");

    // odd inputs unused in bridged mode
    cur = "R5";
    for (int i = 0; i < 6; i++) begin
      pwm[1] = ~pwm[1]; wait_n(1);
      pwm[3] = ~pwm[3]; wait_n(1);
      expect_out(4'b0101, 4'b1010, "R5");
    end
    pwm = 4'b0101;
    wait_n(2);

    // mode pin ignored after reset
    cur = "R2";
    mode_pin = 1'b0;
    pwm = 4'b0001;
    wait_n(DT + 3);
    expect_out(4'b1001, 4'b0110, "R2");

    // latency of one change
    cur = "R8";
    pwm = 4'b0101;
    wait_n(DT + 1);
    expect_out(4'b0001, 4'b0010, "R8");
    wait_n(1);
    expect_out(4'b0101, 4'b1010, "R8");

    // restart inside the interval
    cur = "R7";
    for (int i = 0; i < 4; i++) begin
      pwm[0] = ~pwm[0];
      wait_n(2);
    end
    wait_n(DT - 1);
    expect_out(4'b0100, 4'b1000, "R7");
    wait_n(1);
    expect_out(4'b0101, 4'b1010, "R7");

    // mute
    cur = "R9";
    mute = 1'b1;
    wait_n(10);
    expect_out(4'b0101, 4'b1010, "R9");
    pwm = 4'b0001;
    wait_n(3);
    expect_out(4'h0, 4'h0, "R9");
    wait_n(10);
    expect_out(4'h0, 4'h0, "R9");
    mute = 1'b0;
    wait_n(10);
    expect_out(4'h0, 4'h0, "R9");
    pwm = 4'b0101;
    wait_n(DT + 2);
    expect_out(4'h0, 4'h0, "R9");
    wait_n(1);
    expect_out(4'b0101, 4'b1010, "R9");

    // faults
    cur = "R10";
    fault_pulse(3'b001, 3'b001);
    for (int i = 0; i < 3; i++) begin
      pwm = ~pwm;
      wait_n(DT + 3);
      expect_out(4'h0, 4'h0, "R10");
      chk(stat == 3'b001, "R10", {5'd0, stat}, 8'h01);
    end
    cur = "R11";
    fault_pulse(3'b010, 3'b011);
    fault_pulse(3'b100, 3'b111);

    // reset clears faults, single-ended mode
    cur = "R1";
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(1);
    chk(stat == 0, "R1", {5'd0, stat}, 8'h0);
    expect_out(4'h0, 4'h0, "R1");

    cur = "R4";
    foreach (pwm[i]) begin end
    for (int i = 0; i < 5; i++) begin
      logic [3:0] v;
      case (i)
        0: v = 4'b0000;
        1: v = 4'b1111;
        2: v = 4'b0110;
        3: v = 4'b1010;
        default: v = 4'b0011;
      endcase
      pwm = v;
      wait_n(DT + 3);
      expect_out(v, ~v, "R4");
    end

    // random traffic, single-ended then bridged
    cur = "R6";
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(0, 3) == 0) pwm = 4'($urandom);
      if ($urandom_range(0, 40) == 0) mute = ~mute;
      wait_n(1);
    end
    mute = 1'b0;
    rst = 1'b1; mode_pin = 1'b1;
    wait_n(2);
    rst = 1'b0;
    cur = "R7";
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(0, 4) == 0) pwm = 4'($urandom);
      if ($urandom_range(0, 40) == 0) mute = ~mute;
      wait_n(1);
    end
    wait_n(DT + 4);
    finish_tb();
  end

endmodule